// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

A clocked, synthesizable stand-in for an asynchronous 16-bit static memory. The word is split into two 8-bit lanes, and each lane has its own active-low enable. The block takes a parameterised address and the following controls: an active-low select, an active-high select, an active-low output enable and an active-low write enable. From these it decodes one of four modes: standby, output-disabled, read or write. Only the lanes whose enables are low take part in a read or a write.

Real three-state pins are replaced by a data-out bus and a per-lane drive vector. A lane of the data-out bus carries memory data only while its drive bit is high, and reads zero otherwise. A write commits when its strobe ends. The data committed is the input value registered one cycle before that end, so the data needs no hold time. Read data becomes valid a fixed number of cycles, `ACC_LAT`, after the address, the lane enables and the read controls have all settled. A standby flag is provided for power accounting.

Top module: `byte_lane_sram`

## Requirements
- R1: After reset with the part deselected, `standby` is 1, `lane_oe` is 2'b00 and `dout` is 16'h0000.
- R2: `standby` is 1 and `lane_oe` is 2'b00 whenever `cs1_n` is 1, or `cs2` is 0, or both `lb_n` and `ub_n` are 1.
- R3: A word written with both lane enables low is read back unchanged, with `lane_oe` = 2'b11.
- R4: A write with only `lb_n` low changes only bits 7:0 of the stored word. A write with only `ub_n` low changes only bits 15:8.
- R5: A read drives only the enabled lanes. `lane_oe[0]` belongs to `lb_n` and bits 7:0; `lane_oe[1]` belongs to `ub_n` and bits 15:8. The bits of a lane that is not driven read 0.
- R6: While the part is selected with `we_n` = 1 and `oe_n` = 1, `lane_oe` stays 2'b00 and `standby` is 0.
- R7: A write ended by `we_n` rising stores the `din` value present in the last cycle of the write. A new value presented in the same cycle as the rising edge is not stored.
- R8: A write ended by `cs2` falling or by `cs1_n` rising stores its data, exactly as a write ended by `we_n` does.
- R9: When `we_n` and `oe_n` are both 0 on a selected part, the cycle is a write: `lane_oe` stays 2'b00 and the data is stored.
- R10: `lane_oe` rises only after `ACC_LAT` rising clock edges with the address, the lane enables and the read mode all unchanged. Any change to these drops `lane_oe` at once.
- R11: The address is held stable for as long as a write is active, that is while `cs1_n` = 0, `cs2` = 1 and `we_n` = 0. A write held for several cycles lands at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lb_n | input | 1 | Active-low enable for bits 7:0 |
| ub_n | input | 1 | Active-low enable for bits 15:8 |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; bits of an undriven lane read 0 |
| lane_oe | output | 2 | Per-lane drive indication (bit 0 = low lane) |
| standby | output | 1 | High while the part is deselected |

## Verification
Word and single-lane writes are mixed at the same address. A word read after them separates correct lane masking from whole-word overwrites, and single-lane reads show whether each drive bit is tied to the correct half of the bus. Writes are ended in three ways: by `we_n`, by `cs2` and by `cs1_n`. One of these endings also changes `din` on the terminating cycle, which tells a zero-hold capture apart from sampling live data. Reads are sampled one cycle before and exactly at the access latency, and again just after an address change, so an early or a stale drive is caught.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_STANDBY,
        MODE_NO_OUT,
        MODE_READ,
        MODE_WRITE
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [LANES-1:0]  lanes;
    } ctrl_t;

    typedef struct packed {
        logic [LANES-1:0]  lanes;
        logic [WORD_W-1:0] data;
    } wr_beat_t;

    function automatic mode_e decode_mode(
        input logic             sel_lo_n,
        input logic             sel_hi,
        input logic             out_en_n,
        input logic             wr_en_n,
        input logic [LANES-1:0] lanes
    );
        if (sel_lo_n || !sel_hi || (lanes == '0)) return MODE_STANDBY;
        if (!wr_en_n)                             return MODE_WRITE;
        if (!out_en_n)                            return MODE_READ;
        return MODE_NO_OUT;
    endfunction

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
    import sram_emu_pkg::*;
(
    input  logic  cs1_n,
    input  logic  cs2,
    input  logic  oe_n,
    input  logic  we_n,
    input  logic  lb_n,
    input  logic  ub_n,
    output ctrl_t ctrl
);
    logic [LANES-1:0] lane_en;

    always_comb begin
        lane_en    = {~ub_n, ~lb_n};
        ctrl.lanes = lane_en;
        ctrl.mode  = decode_mode(cs1_n, cs2, oe_n, we_n, lane_en);
    end
endmodule

// File: rtl/sram_write_strobe.sv
module sram_write_strobe
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output wr_beat_t          commit_beat
);
    logic              wr_now;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    wr_beat_t          beat_q;

    assign wr_now = (ctrl.mode == MODE_WRITE);

    // The strobe ends on the first edge that sees the write gone; the data
    // and lanes used are those registered during the last active cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            beat_q <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now) begin
                addr_q       <= addr;
                beat_q.lanes <= ctrl.lanes;
                beat_q.data  <= din;
            end
        end
    end

    assign commit      = wr_q && !wr_now;
    assign commit_addr = addr_q;
    assign commit_beat = beat_q;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  wr_beat_t          wbeat,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbeat.lanes[g]) begin
                cells[waddr] <= wbeat.data[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/sram_read_timer.sv
module sram_read_timer
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam int CW = $clog2(ACC_LAT + 1);
    localparam logic [CW-1:0] LAT_C = CW'(ACC_LAT);

    logic              rd_now;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [CW-1:0]     age;
    logic              same;

    assign rd_now = (ctrl.mode == MODE_READ);
    assign same   = rd_now && rd_q && (addr == addr_q) && (ctrl.lanes == lanes_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            addr_q  <= '0;
            lanes_q <= '0;
            age     <= '0;
        end else begin
            rd_q    <= rd_now;
            addr_q  <= addr;
            lanes_q <= ctrl.lanes;
            if (!rd_now)           age <= '0;
            else if (!same)        age <= CW'(1);
            else if (age < LAT_C)  age <= age + CW'(1);
        end
    end

    assign ready = same && (age >= LAT_C);
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic [1:0]        lane_oe,
    output logic              standby
);
    ctrl_t             ctrl;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    wr_beat_t          commit_beat;
    logic [WORD_W-1:0] rdata;
    logic              ready;

    sram_ctrl_decode u_dec (
        .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n), .ctrl(ctrl)
    );

    sram_write_strobe #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .ctrl(ctrl), .addr(addr), .din(din),
        .commit(commit), .commit_addr(commit_addr), .commit_beat(commit_beat)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(commit), .waddr(commit_addr), .wbeat(commit_beat),
        .raddr(addr), .rdata(rdata)
    );

    sram_read_timer #(.ADDR_W(ADDR_W), .ACC_LAT(ACC_LAT)) u_tmr (
        .clk(clk), .rst(rst), .ctrl(ctrl), .addr(addr), .ready(ready)
    );

    assign standby = (ctrl.mode == MODE_STANDBY);
    assign lane_oe = (ctrl.mode == MODE_READ && ready) ? ctrl.lanes : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dout[g*LANE_W +: LANE_W] =
            lane_oe[g] ? rdata[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_emu_checker.sv
module sram_emu_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              cs1_n,
    input logic              cs2,
    input logic              oe_n,
    input logic              we_n,
    input logic              lb_n,
    input logic              ub_n,
    input logic [1:0]        lane_oe,
    input logic              standby
);
    logic wr_sel;
    assign wr_sel = !cs1_n && cs2 && !we_n;

    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        standby |-> (lane_oe == 2'b00));

    a_r6_oe_high_quiet: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (lane_oe == 2'b00));

    a_r9_write_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_sel |-> (lane_oe == 2'b00));

    a_r5_lane_mask: assert property (@(posedge clk) disable iff (rst)
        (|lane_oe) |-> ((lane_oe & ~{ub_n, lb_n}) == lane_oe));

    a_r10_settled_before_drive: assert property (@(posedge clk) disable iff (rst)
        (|lane_oe) |-> $stable(addr));

    a_r11_addr_hold_write: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && $past(wr_sel)) |-> $stable(addr));
endmodule

bind byte_lane_sram sram_emu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
    .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n),
    .lane_oe(lane_oe), .standby(standby)
);

// File: tb/test_byte_lane_sram.sv
`timescale 1ns/1ps
module test_byte_lane_sram;
    localparam int AW  = 8;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          cs1_n, cs2, oe_n, we_n, lb_n, ub_n;
    logic [15:0]   din;
    logic [15:0]   dout;
    logic [1:0]    lane_oe;
    logic          standby;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    byte_lane_sram #(.ADDR_W(AW), .ACC_LAT(LAT)) i_byte_lane_sram (
        .clk(clk), .rst(rst), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
        .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .din(din),
        .dout(dout), .lane_oe(lane_oe), .standby(standby)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        cs1_n = 1'b1; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        lb_n = 1'b0; ub_n = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic lbn, input logic ubn);
        @(negedge clk);
        addr = a; din = d; cs1_n = 1'b0; cs2 = 1'b1; oe_n = 1'b1;
        lb_n = lbn; ub_n = ubn; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic lbn, input logic ubn,
                           output logic [15:0] d, output logic [1:0] oe);
        @(negedge clk);
        addr = a; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        lb_n = lbn; ub_n = ubn;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        d = dout; oe = lane_oe;
        go_idle();
    endtask

    task automatic t_reset();
        go_idle(); addr = '0; din = '0; rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 standby", {31'b0, standby}, 32'd1);
        chk("R1 lane_oe", {30'b0, lane_oe}, 32'd0);
        chk("R1 dout", {16'b0, dout}, 32'd0);
    endtask

    task automatic t_standby();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            addr = 8'h12; we_n = 1'b1; oe_n = 1'b0;
            cs1_n = (k == 0); cs2 = (k != 1);
            lb_n = (k == 2); ub_n = (k == 2);
            repeat (LAT + 1) @(posedge clk);
            @(negedge clk);
            chk("R2 standby", {31'b0, standby}, 32'd1);
            chk("R2 lane_oe", {30'b0, lane_oe}, 32'd0);
        end
        go_idle();
    endtask

    task automatic t_word();
        logic [15:0] d; logic [1:0] oe;
        do_write(8'h12, 16'hA55A, 1'b0, 1'b0);
        do_read(8'h12, 1'b0, 1'b0, d, oe);
        chk("R3 data", {16'b0, d}, 32'hA55A);
        chk("R3 lane_oe", {30'b0, oe}, 32'd3);
    endtask

    task automatic t_byte_write();
        logic [15:0] d; logic [1:0] oe;
        do_write(8'h20, 16'h1234, 1'b0, 1'b0);
        do_write(8'h20, 16'hFFEE, 1'b0, 1'b1);
        do_read(8'h20, 1'b0, 1'b0, d, oe);
        chk("R4 low lane write", {16'b0, d}, 32'h12EE);
        do_write(8'h20, 16'h77FF, 1'b1, 1'b0);
        do_read(8'h20, 1'b0, 1'b0, d, oe);
        chk("R4 high lane write", {16'b0, d}, 32'h77EE);
    endtask

    task automatic t_byte_read();
        logic [15:0] d; logic [1:0] oe;
        do_read(8'h20, 1'b0, 1'b1, d, oe);
        chk("R5 low read oe", {30'b0, oe}, 32'd1);
        chk("R5 low read data", {16'b0, d}, 32'h00EE);
        do_read(8'h20, 1'b1, 1'b0, d, oe);
        chk("R5 high read oe", {30'b0, oe}, 32'd2);
        chk("R5 high read data", {16'b0, d}, 32'h7700);
    endtask

    task automatic t_out_disabled();
        @(negedge clk);
        addr = 8'h12; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        lb_n = 1'b0; ub_n = 1'b0;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk("R6 lane_oe", {30'b0, lane_oe}, 32'd0);
        chk("R6 standby", {31'b0, standby}, 32'd0);
        go_idle();
    endtask

    task automatic t_priority();
        logic [15:0] d; logic [1:0] oe;
        @(negedge clk);
        addr = 8'h30; din = 16'hC3C3; cs1_n = 1'b0; cs2 = 1'b1;
        oe_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        chk("R9 lane_oe during write", {30'b0, lane_oe}, 32'd0);
        chk("R9 standby", {31'b0, standby}, 32'd0);
        we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        go_idle();
        do_read(8'h30, 1'b0, 1'b0, d, oe);
        chk("R9 stored", {16'b0, d}, 32'hC3C3);
    endtask

    task automatic t_zero_hold();
        logic [15:0] d; logic [1:0] oe;
        @(negedge clk);
        addr = 8'h40; din = 16'h1111; cs1_n = 1'b0; cs2 = 1'b1;
        oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; din = 16'h2222;
        @(negedge clk);
        go_idle();
        do_read(8'h40, 1'b0, 1'b0, d, oe);
        chk("R7 last-cycle data", {16'b0, d}, 32'h1111);
    endtask

    task automatic t_cs_end();
        logic [15:0] d; logic [1:0] oe;
        @(negedge clk);
        addr = 8'h50; din = 16'h5AA5; cs1_n = 1'b0; cs2 = 1'b1;
        oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        cs2 = 1'b0;
        @(negedge clk);
        go_idle();
        do_read(8'h50, 1'b0, 1'b0, d, oe);
        chk("R8 end by cs2", {16'b0, d}, 32'h5AA5);
        @(negedge clk);
        addr = 8'h51; din = 16'h6BB6; cs1_n = 1'b0; cs2 = 1'b1;
        oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        cs1_n = 1'b1;
        @(negedge clk);
        go_idle();
        do_read(8'h51, 1'b0, 1'b0, d, oe);
        chk("R8 end by cs1_n", {16'b0, d}, 32'h6BB6);
    endtask

    task automatic t_latency();
        @(negedge clk);
        addr = 8'h12; cs1_n = 1'b0; cs2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        lb_n = 1'b0; ub_n = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R10 not yet valid", {30'b0, lane_oe}, 32'd0);
        @(negedge clk);
        chk("R10 valid at latency", {30'b0, lane_oe}, 32'd3);
        chk("R10 data", {16'b0, dout}, 32'hA55A);
        addr = 8'h20;
        #1;
        chk("R10 drop on address change", {30'b0, lane_oe}, 32'd0);
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        chk("R10 new address data", {16'b0, dout}, 32'h77EE);
        go_idle();
    endtask

    task automatic t_long_write();
        logic [15:0] d; logic [1:0] oe;
        @(negedge clk);
        addr = 8'h60; din = 16'h0F0F; cs1_n = 1'b0; cs2 = 1'b1;
        oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
        do_read(8'h60, 1'b0, 1'b0, d, oe);
        chk("R11 held-address write", {16'b0, d}, 32'h0F0F);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_standby();
        t_word();
        t_byte_write();
        t_byte_read();
        t_out_disabled();
        t_priority();
        t_zero_hold();
        t_cs_end();
        t_latency();
        t_long_write();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule